// File: doc/BRIEF.md
# Faulty PE Substitution Controller

This block guards a group of four multiply-accumulate processing elements. Each PE takes two signed operands and an incoming partial sum and registers `psum + a*b` on its result output. An external detector raises a per-PE fault flag alongside the operands. When one or two PEs are flagged, the controller asks the surrounding accelerator to hold its operands for one extra cycle. In that cycle it lends healthy neighbours to the flagged lanes and writes their results onto the flagged outputs. The healthy lanes keep their results from the previous cycle.

With a single flagged PE, its operands go to the next PE in rotation. With two flagged PEs, the two healthy PEs take over in index order. With three or four flagged PEs no repair is possible: the controller raises an uncorrectable flag, does not stall, and passes the raw results through. A per-PE corruption input models a tampered datapath, so that the repair can be exercised.

Top module: `pe_group_guard`

## Requirements
- R1: While reset is asserted, and after it is released with clear inputs, every result output is zero and both `stall_o` and `unfix_o` are low.
- R2: With no fault flag set, each lane's result equals `psum + a*b` one clock edge after the operands are applied. Operands are 8-bit two's complement, the sum wraps modulo 2^24, and there is no stall.
- R3: With exactly one flag set, on lane i, `stall_o` is high in the cycle the operands are presented. After the second edge, lane i shows the result that PE (i+1) mod 4 computes from lane i's operands.
- R4: In a single-fault event, the other three lanes keep, through the stall edge, the values they captured at the first edge.
- R5: With exactly two flags set, `stall_o` is high in the operand cycle. After the second edge, the lower-index flagged lane shows the result of the lower-index healthy PE, and the higher-index flagged lane shows the result of the higher-index healthy PE, each computed on the flagged lane's operands.
- R6: In a two-fault event, the two healthy lanes keep, through the stall edge, the values they captured at the first edge.
- R7: With three or more flags set, `unfix_o` is high and `stall_o` is low, and every lane registers its own PE's raw result (corruption included) one edge later.
- R8: `stall_o` is never high in two consecutive cycles, and each fault event presented back-to-back gets its own one-cycle stall.
- R9: When `inj_i[p]` is set, PE p's own result is XORed with 0x5A5A5A. A flagged lane therefore shows that corrupted value between the two edges of its fault event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| arst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| op_a_i | input | 4x8 | First signed operand per lane |
| op_b_i | input | 4x8 | Second signed operand per lane |
| psum_i | input | 4x24 | Incoming partial sum per lane |
| flt_i | input | 4 | Fault flag per lane from the external detector |
| inj_i | input | 4 | Per-PE datapath corruption (test model of a tampered PE) |
| res_o | output | 4x24 | Registered result per lane |
| stall_o | output | 1 | Request to hold operands for one extra cycle |
| unfix_o | output | 1 | Three or more lanes flagged; no repair |

## Verification
The bench builds the block with its default parameters: four lanes, 8-bit operands and a 24-bit sum. At that size it can walk every single-fault lane and every one of the six fault pairs. The full operand range is also reachable, including the -128 x -128 product that wraps the sum. Corruption is injected on flagged lanes and also on a healthy lane that is not the intended partner. A wrong choice of borrowed PE therefore shows up as a wrong value on a port, and not only as a mismatch in internal routing.

// File: rtl/pe_group_guard_pkg.sv
package pe_group_guard_pkg;
  typedef enum logic {
    ST_RUN = 1'b0,
    ST_FIX = 1'b1
  } sub_state_e;
endpackage

// File: rtl/pe_rst_sync.sv
module pe_rst_sync (
  input  logic clk_i,
  input  logic arst_ni,
  output logic rst_no
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk_i or negedge arst_ni) begin
    if (!arst_ni) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_no = sync_q;
endmodule

// File: rtl/pe_mac.sv
module pe_mac #(
  parameter int               OP_W     = 8,
  parameter int               ACC_W    = 24,
  parameter logic [ACC_W-1:0] INJ_MASK = 24'h5A5A5A
) (
  input  logic [OP_W-1:0]  a_i,
  input  logic [OP_W-1:0]  b_i,
  input  logic [ACC_W-1:0] c_i,
  input  logic             inj_i,
  output logic [ACC_W-1:0] r_o
);
  localparam int PW = 2 * OP_W;

  logic signed [PW-1:0] prod;
  logic [ACC_W-1:0]     prod_ext;
  logic [ACC_W-1:0]     sum;

  always_comb begin
    prod     = $signed(a_i) * $signed(b_i);
    prod_ext = {{(ACC_W-PW){prod[PW-1]}}, prod};
    sum      = c_i + prod_ext;
    r_o      = inj_i ? (sum ^ INJ_MASK) : sum;
  end
endmodule

// File: rtl/pe_fault_map.sv
module pe_fault_map #(
  parameter int NPE = 4
) (
  input  logic [NPE-1:0]                 flt_i,
  output logic                           fixable_o,
  output logic                           unfix_o,
  output logic [NPE-1:0][$clog2(NPE)-1:0] partner_o,
  output logic [NPE-1:0][$clog2(NPE)-1:0] srcsel_o
);
  localparam int IW = $clog2(NPE);
  localparam int CW = $clog2(NPE + 1);

  logic [CW-1:0] cnt;
  logic [IW-1:0] fa, fb, ha, hb;
  logic          f_got, h_got, h2_got;

  always_comb begin
    cnt = '0;
    for (int i = 0; i < NPE; i++) cnt = cnt + CW'(flt_i[i]);
  end

  assign fixable_o = (cnt == CW'(1)) || (cnt == CW'(2));
  assign unfix_o   = (cnt >= CW'(3));

  // find first two flagged and first two healthy lanes
  always_comb begin
    fa = '0; fb = '0; ha = '0; hb = '0;
    f_got = 1'b0; h_got = 1'b0; h2_got = 1'b0;
    for (int i = 0; i < NPE; i++) begin
      if (flt_i[i]) begin
        if (!f_got) begin
          fa    = IW'(i);
          f_got = 1'b1;
        end else begin
          fb = IW'(i);
        end
      end else begin
        if (!h_got) begin
          ha    = IW'(i);
          h_got = 1'b1;
        end else if (!h2_got) begin
          hb     = IW'(i);
          h2_got = 1'b1;
        end
      end
    end
  end

  // partner per flagged lane, and operand source per PE
  always_comb begin
    for (int i = 0; i < NPE; i++) begin
      partner_o[i] = IW'(i);
      srcsel_o[i]  = IW'(i);
    end
    if (cnt == CW'(1)) begin
      for (int i = 0; i < NPE; i++) begin
        if (flt_i[i]) partner_o[i] = (i == NPE - 1) ? '0 : IW'(i + 1);
      end
    end else if (cnt == CW'(2)) begin
      partner_o[fa] = ha;
      partner_o[fb] = hb;
    end
    if (fixable_o) begin
      for (int i = 0; i < NPE; i++) begin
        if (flt_i[i]) srcsel_o[partner_o[i]] = IW'(i);
      end
    end
  end
endmodule

// File: rtl/pe_sub_ctrl.sv
module pe_sub_ctrl
  import pe_group_guard_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fixable_i,
  output logic stall_o,
  output logic fix_o
);
  sub_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_RUN:  if (fixable_i) st_d = ST_FIX;
      ST_FIX:  st_d = ST_RUN;
      default: st_d = ST_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) st_q <= ST_RUN;
    else         st_q <= st_d;
  end

  assign stall_o = (st_q == ST_RUN) && fixable_i;
  assign fix_o   = (st_q == ST_FIX);
endmodule

// File: rtl/pe_group_guard.sv
module pe_group_guard #(
  parameter int               NPE      = 4,
  parameter int               OP_W     = 8,
  parameter int               ACC_W    = 24,
  parameter logic [ACC_W-1:0] INJ_MASK = 24'h5A5A5A
) (
  input  logic                       clk_i,
  input  logic                       arst_ni,
  input  logic [NPE-1:0][OP_W-1:0]   op_a_i,
  input  logic [NPE-1:0][OP_W-1:0]   op_b_i,
  input  logic [NPE-1:0][ACC_W-1:0]  psum_i,
  input  logic [NPE-1:0]             flt_i,
  input  logic [NPE-1:0]             inj_i,
  output logic [NPE-1:0][ACC_W-1:0]  res_o,
  output logic                       stall_o,
  output logic                       unfix_o
);
  localparam int IW = $clog2(NPE);

  logic                      rst_sync_n;
  logic                      fixable;
  logic                      fix_q;
  logic [NPE-1:0][IW-1:0]    partner;
  logic [NPE-1:0][IW-1:0]    srcsel;
  logic [NPE-1:0][ACC_W-1:0] pe_res;
  logic [NPE-1:0][ACC_W-1:0] res_q, res_d;
  logic [NPE-1:0]            res_en;

  pe_rst_sync u_rst (
    .clk_i  (clk_i),
    .arst_ni(arst_ni),
    .rst_no (rst_sync_n)
  );

  pe_fault_map #(.NPE(NPE)) u_map (
    .flt_i    (flt_i),
    .fixable_o(fixable),
    .unfix_o  (unfix_o),
    .partner_o(partner),
    .srcsel_o (srcsel)
  );

  pe_sub_ctrl u_ctrl (
    .clk_i    (clk_i),
    .rst_ni   (rst_sync_n),
    .fixable_i(fixable),
    .stall_o  (stall_o),
    .fix_o    (fix_q)
  );

  for (genvar p = 0; p < NPE; p++) begin : g_pe
    logic [IW-1:0] src;
    assign src = fix_q ? srcsel[p] : IW'(p);
    pe_mac #(.OP_W(OP_W), .ACC_W(ACC_W), .INJ_MASK(INJ_MASK)) u_mac (
      .a_i  (op_a_i[src]),
      .b_i  (op_b_i[src]),
      .c_i  (psum_i[src]),
      .inj_i(inj_i[p]),
      .r_o  (pe_res[p])
    );
  end

  // next-state: normal capture, or repair of flagged lanes in the stall cycle
  always_comb begin
    for (int i = 0; i < NPE; i++) begin
      res_d[i]  = res_q[i];
      res_en[i] = 1'b0;
      if (!fix_q) begin
        res_en[i] = 1'b1;
        res_d[i]  = pe_res[i];
      end else if (flt_i[i]) begin
        res_en[i] = 1'b1;
        res_d[i]  = pe_res[partner[i]];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      res_q <= '0;
    end else begin
      for (int i = 0; i < NPE; i++) begin
        if (res_en[i]) res_q[i] <= res_d[i];
      end
    end
  end

  assign res_o = res_q;
endmodule

// File: rtl/pe_group_guard_chk.sv
module pe_group_guard_chk #(
  parameter int NPE   = 4,
  parameter int ACC_W = 24
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic [NPE-1:0]            flt_i,
  input logic [NPE-1:0][ACC_W-1:0] res_o,
  input logic                      stall_o,
  input logic                      unfix_o,
  input logic                      fix_q
);
  assert_stall_once_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |=> !stall_o);

  assert_stall_cause_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_o |-> ($countones(flt_i) == 1 || $countones(flt_i) == 2));

  assert_unfix_nostall_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    unfix_o |-> (!stall_o && $countones(flt_i) >= 3));

  assert_clean_quiet_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flt_i == '0) |-> (!stall_o && !unfix_o));

  // healthy lanes hold through the repair edge (R4 single, R6 pair)
  for (genvar i = 0; i < NPE; i++) begin : g_hold
    assert_hold_healthy_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (fix_q && !flt_i[i]) |=> $stable(res_o[i]));
  end
endmodule

bind pe_group_guard pe_group_guard_chk #(.NPE(NPE), .ACC_W(ACC_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_sync_n),
  .flt_i  (flt_i),
  .res_o  (res_o),
  .stall_o(stall_o),
  .unfix_o(unfix_o),
  .fix_q  (fix_q)
);

// File: tb/pe_group_guard_tb.sv
`timescale 1ns/100ps
module pe_group_guard_tb;
  localparam logic [23:0] MASK = 24'h5A5A5A;

  logic                 clk = 1'b0;
  logic                 arst_n;
  logic [3:0][7:0]      a, b;
  logic [3:0][23:0]     c;
  logic [3:0]           flt, inj;
  logic [3:0][23:0]     res;
  logic                 stall, unfix;

  int n_chk = 0;
  int n_bad = 0;
  int cyc   = 0;
  bit done  = 0;
  int seed  = 32'h1234_5678;

  typedef struct {
    int               due;
    int               req;
    logic [3:0][23:0] exp;
  } item_t;
  item_t sb[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pe_group_guard u_dut (
    .clk_i(clk), .arst_ni(arst_n), .op_a_i(a), .op_b_i(b), .psum_i(c),
    .flt_i(flt), .inj_i(inj), .res_o(res), .stall_o(stall), .unfix_o(unfix)
  );

  function automatic logic [23:0] ideal(logic [7:0] x, logic [7:0] y, logic [23:0] s);
    int p;
    p = $signed(x) * $signed(y);
    return s + 24'(p);
  endfunction

  function automatic logic [23:0] mk(logic f);
    return f ? MASK : 24'h0;
  endfunction

  function automatic int rnd();
    seed = seed * 1103515245 + 12345;
    return (seed >>> 8);
  endfunction

  task automatic chk(int req, logic [23:0] got, logic [23:0] exp, string what);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL R%0d %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  // monitor: pops scoreboard items when due
  always @(negedge clk) begin
    while (sb.size() > 0 && sb[0].due == cyc) begin
      item_t it;
      it = sb.pop_front();
      for (int l = 0; l < 4; l++)
        chk(it.req, res[l], it.exp[l], $sformatf("lane %0d result", l));
    end
  end

  // driver: call at a negedge; returns at the negedge where next vector may go
  task automatic apply(int req, logic [3:0] f, logic [3:0] j);
    logic [3:0][23:0] id, e1, e2;
    int nf;
    int par [4];
    int fl [$];
    int hl [$];
    flt = f; inj = j;
    nf = $countones(f);
    for (int l = 0; l < 4; l++) begin
      id[l] = ideal(a[l], b[l], c[l]);
      e1[l] = id[l] ^ mk(j[l]);
      if (f[l]) fl.push_back(l); else hl.push_back(l);
      par[l] = l;
    end
    if (nf == 1) par[fl[0]] = (fl[0] + 1) % 4;
    if (nf == 2) begin par[fl[0]] = hl[0]; par[fl[1]] = hl[1]; end
    for (int l = 0; l < 4; l++)
      e2[l] = f[l] ? (id[l] ^ mk(j[par[l]])) : e1[l];
    #1;
    chk(req, 24'(stall), 24'(nf == 1 || nf == 2), "stall in operand cycle");
    chk(req, 24'(unfix), 24'(nf >= 3), "uncorrectable flag");
    if (nf == 1 || nf == 2) begin
      sb.push_back('{due: cyc + 1, req: 9, exp: e1});
      sb.push_back('{due: cyc + 2, req: req, exp: e2});
      @(negedge clk);
      #1;
      chk(8, 24'(stall), 24'(0), "stall second cycle");
      @(negedge clk);
    end else begin
      sb.push_back('{due: cyc + 1, req: req, exp: e1});
      @(negedge clk);
    end
  endtask

  task automatic rand_ops();
    for (int l = 0; l < 4; l++) begin
      a[l] = 8'(rnd()); b[l] = 8'(rnd()); c[l] = 24'(rnd());
    end
  endtask

  initial begin
    arst_n = 1'b0; a = '0; b = '0; c = '0; flt = '0; inj = '0;
    repeat (3) @(negedge clk);
    // R1 during reset
    chk(1, res[0] | res[1] | res[2] | res[3], 24'h0, "results in reset");
    chk(1, 24'({stall, unfix}), 24'h0, "flags in reset");
    arst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(1, res[0] | res[1] | res[2] | res[3], 24'h0, "results after release");
    chk(1, 24'({stall, unfix}), 24'h0, "flags after release");

    // R2 clean vectors, including wrap extremes
    for (int k = 0; k < 8; k++) begin rand_ops(); apply(2, 4'b0000, 4'b0000); end
    a = {4{8'h80}}; b = {4{8'h80}}; c = {24'h7FFFFF, 24'hFFC000, 24'h0, 24'h800000};
    apply(2, 4'b0000, 4'b0000);
    a = {8'h7F, 8'h80, 8'h01, 8'hFF}; b = {8'h80, 8'h7F, 8'hFF, 8'hFF};
    apply(2, 4'b0000, 4'b0000);

    // R3/R4/R9 single faults; also tamper a healthy non-partner lane
    for (int i = 0; i < 4; i++) begin
      rand_ops();
      apply(3, 4'(1 << i), 4'((1 << i) | (1 << ((i + 2) % 4))));
      rand_ops();
      apply(4, 4'(1 << i), 4'(1 << i));
    end

    // R5/R6 all six pairs; tamper the higher healthy lane
    for (int x = 0; x < 4; x++) begin
      for (int y = x + 1; y < 4; y++) begin
        logic [3:0] f;
        int hh;
        f = 4'((1 << x) | (1 << y));
        hh = -1;
        for (int l = 0; l < 4; l++) if (!f[l]) hh = l;
        rand_ops();
        apply(5, f, f | 4'(1 << hh));
        rand_ops();
        apply(6, f, f);
      end
    end

    // R8 back-to-back fault events
    rand_ops(); apply(8, 4'b0100, 4'b0100);
    rand_ops(); apply(8, 4'b0100, 4'b0100);
    rand_ops(); apply(8, 4'b1001, 4'b1001);
    rand_ops(); apply(2, 4'b0000, 4'b0000);

    // R7 three and four flags
    rand_ops(); apply(7, 4'b1011, 4'b1011);
    rand_ops(); apply(7, 4'b1111, 4'b0110);
    rand_ops(); apply(7, 4'b0111, 4'b0000);
    flt = '0; inj = '0;
    repeat (3) @(negedge clk);
    if (sb.size() != 0) begin
      n_chk++; n_bad++;
      $display("FAIL R2 scoreboard: %0d pending expected 0", sb.size());
    end
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    #(5 * 20000);
    if (!done) begin
      done = 1;
      n_chk++; n_bad++;
      $display("FAIL R8 watchdog: run did not finish, expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule